// File: doc/BRIEF.md
# Timer Input Capture Conditioning Channel

This block turns one of three candidate input signals into timestamped capture events for a timer channel. The candidates are two external timer inputs and one internal trigger. A 2-bit selection code, held in the block, chooses among them or leaves the channel idle. The selected signal passes through a two-flop synchronizer. It is then sampled at a rate derived from the peripheral clock and cleaned by a digital filter. The filter changes its output level only after a run of matching samples.

Rising edges of the filtered level are counted by a prescaler. Every 1st, 2nd, 4th or 6th edge latches the value of a free-running counter into a capture register and raises a sticky capture flag. Software clears the flag with a one-cycle clear strobe. One 4-bit filter code sets the sampling divider and the run length together. The selection code can be changed only while the channel is disabled.

The filter works as a two-state machine. F_STEADY means no change is pending. On a sampling tick with a mismatching sample it moves to F_QUALIFY, or it takes the new level at once when the run length is one. F_QUALIFY returns to F_STEADY when a sample matches the current level again, or when the run completes and the level flips. A filter code change forces F_STEADY. The capture flag is a second two-state machine. CAP_CLEAR moves to CAP_PENDING on a capture. CAP_PENDING returns to CAP_CLEAR on a clear strobe without a simultaneous capture.

Top module: `icc_capture_channel`

## Requirements
- R1: The selection code chooses the capture source: 2'b10 takes `src_a`, 2'b01 takes `src_b`, 2'b11 takes `trig_in`, and 2'b00 takes no source, so no capture occurs.
- R2: A write on `sel_wr` loads `sel_wdata` into the selection code only when `chan_en` is 0. A write made while `chan_en` is 1 leaves `sel_state` unchanged.
- R3: With filter code 0 and prescaler code 0, a rising input held steady is captured on the 4th rising clock edge after it appears: two synchronizer stages, one filter stage and one edge stage.
- R4: The filter samples once every D clocks and takes a new level after N consecutive samples show it. The codes map to (D, N) as 0:(1,1), 1:(1,2), 2:(1,4), 3:(1,8), 4:(2,6), 5:(2,8), 6:(4,6), 7:(4,8), 8:(8,6), 9:(8,8), 10:(16,5), 11:(16,6), 12:(16,8), 13:(32,5), 14:(32,6), 15:(32,8).
- R5: A pulse that covers fewer than N samples leaves `filt_level` unchanged and causes no capture.
- R6: A change of `filt_code` restarts the sampling divider and the sample run, and `filt_level` holds its value through the change.
- R7: Only rising edges of the filtered level count as events; a falling edge causes no capture.
- R8: Prescaler code 0, 1, 2 or 3 captures on every 1st, 2nd, 4th or 6th event respectively.
- R9: The prescaler event count returns to zero whenever `chan_en` is 0 or `psc_code` changes.
- R10: A capture loads `count_in` into `cap_value` and sets `cap_flag`. The flag stays set until `flag_clr`, and a capture in the same cycle as `flag_clr` wins.
- R11: No capture occurs while `chan_en` is 0 or the selection code is 2'b00.
- R12: After reset, `cap_value`, `cap_flag`, `sel_state` and `filt_level` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 1 | External timer input selected by code 2'b10 |
| src_b | input | 1 | External timer input selected by code 2'b01 |
| trig_in | input | 1 | Internal trigger selected by code 2'b11 |
| count_in | input | CNT_W | Free-running counter value to capture |
| chan_en | input | 1 | Channel enable |
| sel_wr | input | 1 | Write strobe for the selection code |
| sel_wdata | input | 2 | Selection code to write |
| filt_code | input | 4 | Sampling rate and run-length code |
| psc_code | input | 2 | Event prescaler code |
| flag_clr | input | 1 | Clears the capture flag |
| cap_value | output | CNT_W | Last captured counter value |
| cap_flag | output | 1 | Sticky capture flag |
| sel_state | output | 2 | Current selection code |
| filt_level | output | 1 | Filtered level of the selected source |

## Verification
Each source is pulsed while each selection code is active. This separates a correct source mapping from a swapped or missing one, and a write lock that holds from one that leaks. Pulse widths are set just below and just above N samples at several filter codes, including the slowest sampling rates. This separates the correct divider and run length from off-by-one or mis-tabled ones, and a held code change mid-run shows whether the run restarts. Trains of 12 pulses under each prescaler code, and partial trains interrupted by a code change or a disable, tell the six-way divide and the count clearing apart from an eight-way divide or a count that survives.

// File: rtl/icc_pkg.sv
package icc_pkg;

    localparam int FILT_DIV_W = 5;
    localparam int FILT_LEN_W = 4;
    localparam int PSC_W      = 3;

    localparam logic [1:0] SEL_OFF  = 2'b00;
    localparam logic [1:0] SEL_B    = 2'b01;
    localparam logic [1:0] SEL_A    = 2'b10;
    localparam logic [1:0] SEL_TRIG = 2'b11;

    typedef enum logic {F_STEADY, F_QUALIFY} filt_state_e;
    typedef enum logic {CAP_CLEAR, CAP_PENDING} cap_state_e;

    // Last value of the sampling divider (divide ratio minus one).
    function automatic logic [FILT_DIV_W-1:0] filt_div_last(input logic [3:0] code);
        logic [FILT_DIV_W-1:0] r;
        unique case (code)
            4'd0, 4'd1, 4'd2, 4'd3:  r = 5'd0;
            4'd4, 4'd5:              r = 5'd1;
            4'd6, 4'd7:              r = 5'd3;
            4'd8, 4'd9:              r = 5'd7;
            4'd10, 4'd11, 4'd12:     r = 5'd15;
            default:                 r = 5'd31;
        endcase
        return r;
    endfunction

    // Number of consecutive matching samples required.
    function automatic logic [FILT_LEN_W-1:0] filt_len(input logic [3:0] code);
        logic [FILT_LEN_W-1:0] r;
        unique case (code)
            4'd0:                                    r = 4'd1;
            4'd1:                                    r = 4'd2;
            4'd2:                                    r = 4'd4;
            4'd10, 4'd13:                            r = 4'd5;
            4'd4, 4'd6, 4'd8, 4'd11, 4'd14:          r = 4'd6;
            default:                                 r = 4'd8;
        endcase
        return r;
    endfunction

    // Last value of the prescaler count (ratio minus one).
    function automatic logic [PSC_W-1:0] psc_last(input logic [1:0] code);
        logic [PSC_W-1:0] r;
        unique case (code)
            2'd0:    r = 3'd0;
            2'd1:    r = 3'd1;
            2'd2:    r = 3'd3;
            default: r = 3'd5;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/icc_src_sel.sv
module icc_src_sel
    import icc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic       sel_wr,
    input  logic [1:0] sel_wdata,
    input  logic       src_a,
    input  logic       src_b,
    input  logic       trig_in,
    output logic [1:0] sel_q,
    output logic       synced
);

    logic                   raw;
    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_OFF;
        end else if (sel_wr && !chan_en) begin
            sel_q <= sel_wdata;
        end
    end

    always_comb begin
        unique case (sel_q)
            SEL_A:    raw = src_a;
            SEL_B:    raw = src_b;
            SEL_TRIG: raw = trig_in;
            default:  raw = 1'b0;
        endcase
    end

    // One synchronizer after the mux serves all three sources.
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b0;
                end else if (g == 0) begin
                    chain[g] <= raw;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign synced = chain[SYNC_STAGES-1];

    // R2: selection frozen while the channel is enabled
    a_r2_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> $stable(sel_q));

endmodule

// File: rtl/icc_filter.sv
module icc_filter
    import icc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] code,
    input  logic       din,
    output logic       level
);

    filt_state_e           state, state_n;
    logic [FILT_DIV_W-1:0] div_cnt;
    logic [FILT_LEN_W-1:0] run_cnt, run_cnt_n;
    logic [3:0]            code_q;
    logic                  level_n;
    logic                  restart;
    logic                  tick;
    logic [FILT_DIV_W-1:0] div_last;
    logic [FILT_LEN_W-1:0] len;
    logic [FILT_LEN_W-1:0] run_last;

    assign div_last = filt_div_last(code);
    assign len      = filt_len(code);
    assign run_last = len - 4'd1;
    assign restart  = (code != code_q);
    assign tick     = !restart && (div_cnt == div_last);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= F_STEADY;
            run_cnt <= '0;
            div_cnt <= '0;
            level   <= 1'b0;
            code_q  <= 4'd0;
        end else begin
            code_q <= code;
            if (restart) begin
                state   <= F_STEADY;
                run_cnt <= '0;
                div_cnt <= '0;
            end else begin
                state   <= state_n;
                run_cnt <= run_cnt_n;
                level   <= level_n;
                div_cnt <= tick ? '0 : div_cnt + 5'd1;
            end
        end
    end

    // Next state and output process
    always_comb begin
        state_n   = state;
        run_cnt_n = run_cnt;
        level_n   = level;
        if (tick) begin
            unique case (state)
                F_STEADY: begin
                    if (din != level) begin
                        if (len == 4'd1) begin
                            level_n = din;
                        end else begin
                            run_cnt_n = 4'd1;
                            state_n   = F_QUALIFY;
                        end
                    end
                end
                F_QUALIFY: begin
                    if (din == level) begin
                        run_cnt_n = '0;
                        state_n   = F_STEADY;
                    end else if (run_cnt == run_last) begin
                        level_n   = din;
                        run_cnt_n = '0;
                        state_n   = F_STEADY;
                    end else begin
                        run_cnt_n = run_cnt + 4'd1;
                    end
                end
            endcase
        end
    end

    // R4: level moves only on a sampling tick
    a_r4_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(level));

    // R5: no change before the run completes
    a_r5_no_early_change: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == F_QUALIFY && run_cnt != run_last) |=> $stable(level));

    a_r5_first_sample_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state == F_STEADY && len != 4'd1) |=> $stable(level));

    // R6: level held across a code change
    a_r6_restart_holds: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> $stable(level));

endmodule

// File: rtl/icc_edge_psc.sv
module icc_edge_psc
    import icc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_en,
    input  logic [1:0] psc_code,
    input  logic       level,
    output logic       fire
);

    logic             prev;
    logic [1:0]       code_q;
    logic [PSC_W-1:0] cnt;
    logic [PSC_W-1:0] last;
    logic             rise;
    logic             restart;

    assign last    = psc_last(psc_code);
    assign rise    = level && !prev;
    assign restart = !chan_en || (psc_code != code_q);
    assign fire    = !restart && rise && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev   <= 1'b0;
            code_q <= 2'd0;
            cnt    <= '0;
        end else begin
            prev   <= level;
            code_q <= psc_code;
            if (restart) begin
                cnt <= '0;
            end else if (rise) begin
                cnt <= (cnt == last) ? '0 : cnt + 3'd1;
            end
        end
    end

    // R8: count never exceeds the selected ratio
    a_r8_psc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= psc_last(code_q));

    // R9: count cleared while disabled
    a_r9_cleared_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |=> (cnt == '0));

endmodule

// File: rtl/icc_capture_channel.sv
module icc_capture_channel
    import icc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_a,
    input  logic             src_b,
    input  logic             trig_in,
    input  logic [CNT_W-1:0] count_in,
    input  logic             chan_en,
    input  logic             sel_wr,
    input  logic [1:0]       sel_wdata,
    input  logic [3:0]       filt_code,
    input  logic [1:0]       psc_code,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] cap_value,
    output logic             cap_flag,
    output logic [1:0]       sel_state,
    output logic             filt_level
);

    logic       synced;
    logic       fire;
    logic       capture;
    cap_state_e cstate, cstate_n;

    icc_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_en   (chan_en),
        .sel_wr    (sel_wr),
        .sel_wdata (sel_wdata),
        .src_a     (src_a),
        .src_b     (src_b),
        .trig_in   (trig_in),
        .sel_q     (sel_state),
        .synced    (synced)
    );

    icc_filter u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .code  (filt_code),
        .din   (synced),
        .level (filt_level)
    );

    icc_edge_psc u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_en  (chan_en),
        .psc_code (psc_code),
        .level    (filt_level),
        .fire     (fire)
    );

    assign capture = fire && chan_en && (sel_state != SEL_OFF);

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cstate    <= CAP_CLEAR;
            cap_value <= '0;
        end else begin
            cstate <= cstate_n;
            if (capture) begin
                cap_value <= count_in;
            end
        end
    end

    // Next state and output process
    always_comb begin
        cstate_n = cstate;
        unique case (cstate)
            CAP_CLEAR:   if (capture) cstate_n = CAP_PENDING;
            CAP_PENDING: if (flag_clr && !capture) cstate_n = CAP_CLEAR;
        endcase
    end

    assign cap_flag = (cstate == CAP_PENDING);

    // R10: flag sticky until cleared
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag && !flag_clr) |=> cap_flag);

    // R10: a new value always comes with the flag
    a_r10_value_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap_value) |-> cap_flag);

    // R11: nothing captured while disabled or idle
    a_r11_disabled_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en || sel_state == SEL_OFF) |=> $stable(cap_value));

endmodule

// File: tb/icc_capture_channel_bench.sv
module icc_capture_channel_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             src_a = 1'b0, src_b = 1'b0, trig_in = 1'b0;
    logic [CNT_W-1:0] count_in = '0;
    logic             chan_en = 1'b0, sel_wr = 1'b0, flag_clr = 1'b0;
    logic [1:0]       sel_wdata = 2'b00, psc_code = 2'b00;
    logic [3:0]       filt_code = 4'd0;
    logic [CNT_W-1:0] cap_value;
    logic             cap_flag, filt_level;
    logic [1:0]       sel_state;

    int checks = 0;
    int errors = 0;
    int ncap   = 0;
    int cycles = 0;

    icc_capture_channel #(.CNT_W(CNT_W)) u_icc_capture_channel (
        .clk, .rst_n, .src_a, .src_b, .trig_in, .count_in, .chan_en,
        .sel_wr, .sel_wdata, .filt_code, .psc_code, .flag_clr,
        .cap_value, .cap_flag, .sel_state, .filt_level
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) count_in <= count_in + 1'b1;
    always @(cap_value) if (rst_n) ncap++;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    function automatic int mdl_rate(input int c);
        if (c < 4) return 1;
        if (c < 10) return 1 << ((c - 4) / 2 + 1);
        if (c < 13) return 16;
        return 32;
    endfunction

    function automatic int mdl_len(input int c);
        case (c)
            0: return 1;
            1: return 2;
            2: return 4;
            10, 13: return 5;
            4, 6, 8, 11, 14: return 6;
            default: return 8;
        endcase
    endfunction

    function automatic int mdl_ratio(input int c);
        case (c)
            0: return 1;
            1: return 2;
            2: return 4;
            default: return 6;
        endcase
    endfunction

    bit m_s1, m_s2, m_level, m_prev, m_flag, m_valid;
    int m_div, m_run, m_pcnt, m_sel, m_fq, m_pq;
    int m_val;

    always @(posedge clk or negedge rst_n) begin : model
        bit raw, fire, tick;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_level = 0; m_prev = 0; m_flag = 0;
            m_div = 0; m_run = 0; m_pcnt = 0; m_sel = 0; m_fq = 0; m_pq = 0;
            m_val = 0; m_valid = 1;
        end else begin
            raw = (m_sel == 2) ? src_a : (m_sel == 1) ? src_b :
                  (m_sel == 3) ? trig_in : 1'b0;
            fire = 0;
            if (!chan_en || int'(psc_code) != m_pq) m_pcnt = 0;
            else if (m_level && !m_prev) begin
                if (m_pcnt + 1 == mdl_ratio(psc_code)) begin fire = 1; m_pcnt = 0; end
                else m_pcnt = m_pcnt + 1;
            end
            if (fire && m_sel != 0) begin m_val = count_in; m_flag = 1; end
            else if (flag_clr) m_flag = 0;
            m_prev = m_level;
            if (int'(filt_code) != m_fq) begin
                m_div = 0; m_run = 0;
            end else begin
                tick = (m_div == mdl_rate(filt_code) - 1);
                m_div = tick ? 0 : m_div + 1;
                if (tick) begin
                    if (m_s2 != m_level) begin
                        if (m_run + 1 >= mdl_len(filt_code)) begin m_level = m_s2; m_run = 0; end
                        else m_run = m_run + 1;
                    end else m_run = 0;
                end
            end
            m_s2 = m_s1;
            m_s1 = raw;
            if (sel_wr && !chan_en) m_sel = sel_wdata;
            m_fq = filt_code;
            m_pq = psc_code;
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && m_valid) begin
            check("R4 filt_level vs model", filt_level, m_level);
            check("R10 cap_value vs model", cap_value, m_val);
            check("R10 cap_flag vs model", cap_flag, m_flag);
            check("R2 sel_state vs model", sel_state, m_sel);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drive_src(input int which, input bit v);
        case (which)
            0: src_a = v;
            1: src_b = v;
            default: trig_in = v;
        endcase
    endtask

    task automatic pulse(input int which, input int hi, input int lo);
        drive_src(which, 1'b1);
        wait_n(hi);
        drive_src(which, 1'b0);
        wait_n(lo);
    endtask

    task automatic pulses(input int which, input int n, input int hi, input int lo);
        for (int i = 0; i < n; i++) pulse(which, hi, lo);
    endtask

    task automatic write_sel(input logic [1:0] v);
        sel_wr = 1'b1; sel_wdata = v;
        wait_n(1);
        sel_wr = 1'b0;
        wait_n(1);
    endtask

    task automatic reselect(input logic [1:0] v);
        chan_en = 1'b0; wait_n(1);
        write_sel(v);
        chan_en = 1'b1; wait_n(2);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; wait_n(1);
        flag_clr = 1'b0; wait_n(1);
    endtask

    initial begin
        int c0;
        logic [CNT_W-1:0] v0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R12: reset state
        check("R12 cap_value reset", cap_value, 0);
        check("R12 cap_flag reset", cap_flag, 0);
        check("R12 sel_state reset", sel_state, 0);
        check("R12 filt_level reset", filt_level, 0);

        reselect(2'b10);
        check("R1 select src_a", sel_state, 2);

        // R3: latency of four rising edges
        v0 = cap_value;
        src_a = 1'b1;
        wait_n(3);
        check("R3 no capture before 4th edge", int'(cap_value == v0), 1);
        wait_n(1);
        check("R3 capture on 4th edge", int'(cap_value != v0), 1);
        wait_n(4);
        // R7: falling edge does not capture
        c0 = ncap;
        src_a = 1'b0;
        wait_n(8);
        check("R7 no capture on falling edge", ncap - c0, 0);

        c0 = ncap; pulses(0, 3, 3, 6);
        check("R1 src_a pulses captured", ncap - c0, 3);
        c0 = ncap; pulses(1, 2, 3, 6); pulses(2, 2, 3, 6);
        check("R1 unselected sources ignored", ncap - c0, 0);

        // R2: write while enabled is ignored
        write_sel(2'b01);
        check("R2 locked selection", sel_state, 2);
        c0 = ncap; pulses(1, 2, 3, 6);
        check("R2 src_b still ignored", ncap - c0, 0);

        reselect(2'b01);
        c0 = ncap; pulses(1, 2, 3, 6);
        check("R1 src_b selected", ncap - c0, 2);
        reselect(2'b11);
        c0 = ncap; pulses(2, 2, 3, 6);
        check("R1 trigger selected", ncap - c0, 2);

        // R8: prescaler ratios
        reselect(2'b10);
        psc_code = 2'd1; wait_n(2);
        c0 = ncap; pulses(0, 12, 3, 6);
        check("R8 ratio 2", ncap - c0, 6);
        psc_code = 2'd2; wait_n(2);
        c0 = ncap; pulses(0, 12, 3, 6);
        check("R8 ratio 4", ncap - c0, 3);
        psc_code = 2'd3; wait_n(2);
        c0 = ncap; pulses(0, 12, 3, 6);
        check("R8 ratio 6", ncap - c0, 2);

        // R9: count cleared by code change and by disable
        psc_code = 2'd2; wait_n(2);
        c0 = ncap; pulses(0, 3, 3, 6);
        psc_code = 2'd3; wait_n(1);
        psc_code = 2'd2; wait_n(2);
        pulses(0, 1, 3, 6);
        check("R9 code change clears count", ncap - c0, 0);
        pulses(0, 2, 3, 6);
        chan_en = 1'b0; wait_n(1);
        chan_en = 1'b1; wait_n(2);
        pulses(0, 1, 3, 6);
        check("R9 disable clears count", ncap - c0, 0);
        psc_code = 2'd0; wait_n(2);

        // R4/R5: filter lengths and rates
        filt_code = 4'd3; wait_n(4);
        c0 = ncap; pulse(0, 7, 12);
        check("R5 7-sample pulse rejected, N=8", ncap - c0, 0);
        c0 = ncap; pulse(0, 8, 12);
        check("R4 8-sample pulse accepted, N=8", ncap - c0, 1);
        filt_code = 4'd15; wait_n(4);
        c0 = ncap; pulse(0, 200, 300);
        check("R5 short pulse rejected, D=32 N=8", ncap - c0, 0);
        c0 = ncap; pulse(0, 300, 300);
        check("R4 long pulse accepted, D=32 N=8", ncap - c0, 1);
        filt_code = 4'd10; wait_n(4);
        c0 = ncap; pulse(0, 60, 120);
        check("R5 short pulse rejected, D=16 N=5", ncap - c0, 0);
        c0 = ncap; pulse(0, 100, 120);
        check("R4 long pulse accepted, D=16 N=5", ncap - c0, 1);

        // R6: code change restarts the run
        filt_code = 4'd15; wait_n(4);
        src_a = 1'b1; wait_n(200);
        filt_code = 4'd14; wait_n(150);
        check("R6 level held after restart", filt_level, 0);
        src_a = 1'b0; wait_n(400);
        filt_code = 4'd0; wait_n(4);

        // R10: flag and value
        clear_flag();
        check("R10 flag cleared", cap_flag, 0);
        v0 = cap_value;
        pulse(0, 3, 6);
        check("R10 flag set by capture", cap_flag, 1);
        check("R10 value updated", int'(cap_value != v0), 1);

        // R11: disabled or idle channel
        clear_flag();
        chan_en = 1'b0; wait_n(2);
        c0 = ncap; pulses(0, 2, 3, 6);
        check("R11 disabled no capture", ncap - c0, 0);
        check("R11 disabled flag stays clear", cap_flag, 0);
        reselect(2'b00);
        c0 = ncap; pulses(0, 2, 3, 6); pulses(1, 2, 3, 6); pulses(2, 2, 3, 6);
        check("R11 code 00 no capture", ncap - c0, 0);
        check("R1 code 00 selected", sel_state, 0);

        wait_n(4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule